// File: doc/BRIEF.md
# Handshake-Sequenced Flash Word Reader

This block fetches one 32-bit word from a flash array for every count token it receives on a four-phase push channel. A count of 1 to 4 is turned into a byte address, and the address is presented to the array. The block then waits until its own delayed copy of the address request comes back, which serves as the address acknowledge. Only after that does it raise the sense-amplifier enable. The array answers with a data-valid strobe and the output word. The sense acknowledge is formed only where sense-enable and data-valid are both high, and the word is captured at that point.

Once the sense handshake has returned to zero, the address request is withdrawn. The captured word is then pushed to the storage side on one of four result channels, one per count value. The count token is acknowledged only after that result handshake has completed. A count value outside 1 to 4 is acknowledged at once, and no memory activity takes place.

The design is a cycle-based model of a self-timed controller. The address setup delay is a number of clock cycles. The memory access time is whatever the array takes to raise data-valid.

Top module: `flash_word_reader`

## Requirements
- R1: A count value c of 1, 2, 3 or 4 drives byte address 4*c on `mem_addr` (4, 8, 12, 16) for the read it starts.
- R2: A count value of 0 or of 5 and above is acknowledged on `cnt_ack` with no rise of `mem_se`, no `res_req` and no change of `mem_addr`.
- R3: `mem_se` rises only after the internal address acknowledge, which is the address request delayed by SETUP_CYC cycles, so `mem_addr` has been stable for at least SETUP_CYC cycles at that rise.
- R4: `mem_addr` does not change in any cycle in which `mem_se` or `mem_dvalid` is high.
- R5: The word delivered is the value of `mem_dout` in the first cycle where `mem_se` and `mem_dvalid` are both high. Data-valid while `mem_se` is low has no effect on any output.
- R6: Each read gives exactly one 0-to-1 transition of `mem_se`, and `mem_se` stays high until data-valid is seen.
- R7: The word is offered on `res_word` with `res_req` bit c-1 high (one-hot, bit 0 for count 1). The request is held until the matching `res_ack` bit rises and is dropped before the next step.
- R8: `cnt_ack` rises only after the result handshake has returned to zero, and it stays high until `cnt_req` falls.
- R9: While `rst` is high, and just after it, `cnt_ack`, `mem_se`, `res_req` and `mem_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_req | input | 1 | Count token request (four-phase) |
| cnt_val | input | CNT_W | Count value, valid while `cnt_req` is high |
| cnt_ack | output | 1 | Count token acknowledge |
| mem_addr | output | ADDR_W | Byte address to the flash array |
| mem_se | output | 1 | Sense-amplifier enable (sense request) |
| mem_dvalid | input | 1 | Data-valid strobe from the array |
| mem_dout | input | DATA_W | Output word from the array |
| res_req | output | LANES | One-hot result request, one bit per count value |
| res_word | output | DATA_W | Captured word for the result channels |
| res_ack | input | LANES | Result acknowledge, one bit per channel |

## Verification
A sequencer that leaves its state too early shows up within a cycle as a `mem_se` rise before the address has settled. It also shows up as an address that moves while data-valid is still high. A wrong capture point delivers the array's filler pattern instead of the address-derived word on the result channel of that same token. A wrong mapping of count to lane or address shows up when the four stored words are compared after each token. An acknowledge issued too early is seen as `cnt_ack` rising before the storage side has logged the word.

// File: rtl/frc_pkg.sv
package frc_pkg;

    localparam int unsigned LANES  = 4;
    localparam int unsigned STRIDE = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADR_UP,
        ST_SE_UP,
        ST_SE_DN,
        ST_ADR_DN,
        ST_RES_UP,
        ST_RES_DN,
        ST_CNT_ACK
    } frc_state_e;

    typedef struct packed {
        logic adr_req;
        logic se;
        logic res_en;
        logic cnt_ack;
    } frc_drive_t;

    function automatic logic count_mapped(input int unsigned c);
        return (c >= 1) && (c <= LANES);
    endfunction

    function automatic int unsigned count_to_addr(input int unsigned c);
        return c * STRIDE;
    endfunction

    function automatic int unsigned count_to_lane(input int unsigned c);
        return c - 1;
    endfunction

endpackage

// File: rtl/frc_setup_delay.sv
module frc_setup_delay #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic ack_o
);
    logic [STAGES-1:0] line_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) line_q <= '0;
                else     line_q <= req_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) line_q <= '0;
                else     line_q <= {line_q[STAGES-2:0], req_i};
            end
        end
    endgenerate

    assign ack_o = line_q[STAGES-1];

    AST_DELAY_ACK_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_o) |-> req_i); // R3

endmodule

// File: rtl/frc_sense_join.sv
module frc_sense_join #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              se_i,
    input  logic              dvalid_i,
    input  logic [DATA_W-1:0] dout_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] word_o
);
    logic ack_q;

    assign ack_o = se_i & dvalid_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q  <= 1'b0;
            word_o <= '0;
        end else begin
            ack_q <= ack_o;
            if (ack_o && !ack_q) word_o <= dout_i;
        end
    end

endmodule

// File: rtl/frc_read_fsm.sv
module frc_read_fsm
    import frc_pkg::*;
#(
    parameter int unsigned CNT_W  = 3,
    parameter int unsigned ADDR_W = 8,
    localparam int unsigned LW    = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_req_i,
    input  logic [CNT_W-1:0]  cnt_val_i,
    output logic              cnt_ack_o,
    output logic              adr_req_o,
    input  logic              adr_ack_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              se_o,
    input  logic              sense_ack_i,
    input  logic              dvalid_i,
    output logic [LANES-1:0]  res_req_o,
    input  logic [LANES-1:0]  res_ack_i
);
    frc_state_e state_q, state_d;
    frc_drive_t drv;
    logic [LW-1:0] lane_q;
    logic          mapped;
    logic          lane_ack;

    assign mapped   = count_mapped(int'(cnt_val_i));
    assign lane_ack = res_ack_i[lane_q];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cnt_req_i) state_d = mapped ? ST_ADR_UP : ST_CNT_ACK;
            ST_ADR_UP:  if (adr_ack_i) state_d = ST_SE_UP;
            ST_SE_UP:   if (sense_ack_i) state_d = ST_SE_DN;
            ST_SE_DN:   if (!sense_ack_i && !dvalid_i) state_d = ST_ADR_DN;
            ST_ADR_DN:  if (!adr_ack_i) state_d = ST_RES_UP;
            ST_RES_UP:  if (lane_ack) state_d = ST_RES_DN;
            ST_RES_DN:  if (!lane_ack) state_d = ST_CNT_ACK;
            ST_CNT_ACK: if (!cnt_req_i) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        drv = '0;
        unique case (state_q)
            ST_ADR_UP:  drv.adr_req = 1'b1;
            ST_SE_UP:   begin drv.adr_req = 1'b1; drv.se = 1'b1; end
            ST_SE_DN:   drv.adr_req = 1'b1;
            ST_RES_UP:  drv.res_en  = 1'b1;
            ST_CNT_ACK: drv.cnt_ack = 1'b1;
            default:    drv = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            lane_q  <= '0;
            addr_o  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cnt_req_i && mapped) begin
                lane_q <= LW'(count_to_lane(int'(cnt_val_i)));
                addr_o <= ADDR_W'(count_to_addr(int'(cnt_val_i)));
            end
        end
    end

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign res_req_o[i] = drv.res_en && (lane_q == LW'(i));
        end
    endgenerate

    assign adr_req_o = drv.adr_req;
    assign se_o      = drv.se;
    assign cnt_ack_o = drv.cnt_ack;

    AST_SE_AFTER_ADR_ACK: assert property (@(posedge clk) disable iff (rst)
        $rose(se_o) |-> adr_ack_i); // R3
    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (se_o || dvalid_i) |-> $stable(addr_o)); // R4
    AST_SE_HELD: assert property (@(posedge clk) disable iff (rst)
        (se_o && !sense_ack_i) |=> se_o); // R6
    AST_RES_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(res_req_o)); // R7
    AST_CNT_ACK_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $rose(cnt_ack_o) |-> (res_req_o == '0 && !se_o && !adr_req_o)); // R8
    AST_CNT_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cnt_ack_o && cnt_req_i) |=> cnt_ack_o); // R8

endmodule

// File: rtl/flash_word_reader.sv
module flash_word_reader
    import frc_pkg::*;
#(
    parameter int unsigned CNT_W     = 3,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned SETUP_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_req,
    input  logic [CNT_W-1:0]  cnt_val,
    output logic              cnt_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_se,
    input  logic              mem_dvalid,
    input  logic [DATA_W-1:0] mem_dout,
    output logic [LANES-1:0]  res_req,
    output logic [DATA_W-1:0] res_word,
    input  logic [LANES-1:0]  res_ack
);
    logic adr_req;
    logic adr_ack;
    logic sense_ack;

    frc_setup_delay #(.STAGES(SETUP_CYC)) u_delay (
        .clk   (clk),
        .rst   (rst),
        .req_i (adr_req),
        .ack_o (adr_ack)
    );

    frc_sense_join #(.DATA_W(DATA_W)) u_join (
        .clk      (clk),
        .rst      (rst),
        .se_i     (mem_se),
        .dvalid_i (mem_dvalid),
        .dout_i   (mem_dout),
        .ack_o    (sense_ack),
        .word_o   (res_word)
    );

    frc_read_fsm #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cnt_req_i   (cnt_req),
        .cnt_val_i   (cnt_val),
        .cnt_ack_o   (cnt_ack),
        .adr_req_o   (adr_req),
        .adr_ack_i   (adr_ack),
        .addr_o      (mem_addr),
        .se_o        (mem_se),
        .sense_ack_i (sense_ack),
        .dvalid_i    (mem_dvalid),
        .res_req_o   (res_req),
        .res_ack_i   (res_ack)
    );

endmodule

// File: tb/flash_word_reader_tb.sv
module flash_word_reader_tb_top;
    localparam int SETUP = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_req = 1'b0;
    logic [2:0]  cnt_val = '0;
    logic        cnt_ack;
    logic [7:0]  mem_addr;
    logic        mem_se;
    logic        mem_dvalid;
    logic [31:0] mem_dout;
    logic [3:0]  res_req;
    logic [31:0] res_word;
    logic [3:0]  res_ack;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int acc_lat = 1;
    logic stray = 1'b0;
    logic txn_mapped = 1'b0;

    always #10 clk = ~clk;

    flash_word_reader #(.CNT_W(3), .ADDR_W(8), .DATA_W(32), .SETUP_CYC(SETUP)) dut_i (
        .clk(clk), .rst(rst), .cnt_req(cnt_req), .cnt_val(cnt_val), .cnt_ack(cnt_ack),
        .mem_addr(mem_addr), .mem_se(mem_se), .mem_dvalid(mem_dvalid), .mem_dout(mem_dout),
        .res_req(res_req), .res_word(res_word), .res_ack(res_ack)
    );

    function automatic logic [31:0] word_of(input logic [7:0] a);
        return {8'hC3, a, ~a, a ^ 8'h5A};
    endfunction

    // flash array model
    logic dv_q;
    int   timer;
    always_ff @(posedge clk) begin
        if (rst || !mem_se) begin
            dv_q  <= 1'b0;
            timer <= 0;
        end else if (timer >= acc_lat) begin
            dv_q <= 1'b1;
        end else begin
            timer <= timer + 1;
        end
    end
    assign mem_dvalid = dv_q | stray;
    assign mem_dout   = dv_q ? word_of(mem_addr) : 32'hBAD0_BAD0;

    // storage side
    logic [31:0] store [4];
    int store_events = 0;
    always_ff @(posedge clk) begin
        if (rst) res_ack <= '0;
        else     res_ack <= res_req;
        for (int i = 0; i < 4; i++) begin
            if (!rst && res_req[i] && !res_ack[i]) begin
                store[i] <= res_word;
                store_events <= store_events + 1;
            end
        end
    end

    // port monitors
    logic [7:0] prev_addr = '0;
    logic prev_se = 1'b0, prev_ack = 1'b0;
    int setup_cnt = 0;
    int se_rises = 0;
    int store_at_start = 0;
    always @(negedge clk) begin
        cycles = cycles + 1;
        if (!rst) begin
            if (mem_addr != prev_addr) begin
                setup_cnt = 0;
                if (prev_se || mem_se || mem_dvalid) begin
                    checks++; fails++;
                    $display("FAIL R4: addr changed to %0d from %0d during sense", mem_addr, prev_addr);
                end
            end else setup_cnt++;
            if (mem_se && !prev_se) begin
                se_rises++;
                checks++;
                if (setup_cnt < SETUP) begin
                    fails++;
                    $display("FAIL R3: setup cycles %0d expected >= %0d", setup_cnt, SETUP);
                end
            end
            if (cnt_ack && !prev_ack) begin
                checks++;
                if (txn_mapped && store_events == store_at_start) begin
                    fails++;
                    $display("FAIL R8: cnt_ack rose with stores %0d expected > %0d", store_events, store_at_start);
                end
            end
        end
        prev_addr = mem_addr;
        prev_se   = mem_se;
        prev_ack  = cnt_ack;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_count(input logic [2:0] c);
        @(negedge clk);
        txn_mapped     = (c >= 1 && c <= 4);
        store_at_start = store_events;
        cnt_val = c;
        cnt_req = 1'b1;
        while (!cnt_ack) @(negedge clk);
        cnt_req = 1'b0;
        while (cnt_ack) @(negedge clk);
    endtask

    // {count, access latency}
    localparam logic [7:0] VEC [12] = '{
        8'h10, 8'h23, 8'h31, 8'h4F, 8'h45, 8'h12,
        8'h02, 8'h53, 8'h3A, 8'h71, 8'h20, 8'h65 };

    initial begin
        repeat (3) @(negedge clk);
        check("R9 cnt_ack", 32'(cnt_ack), 0);
        check("R9 mem_se", 32'(mem_se), 0);
        check("R9 res_req", 32'(res_req), 0);
        check("R9 mem_addr", 32'(mem_addr), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 after release", {cnt_ack, mem_se, res_req, mem_addr}, 0);

        for (int v = 0; v < 12; v++) begin
            logic [2:0] c;
            int rises0, st0;
            logic [7:0] addr0;
            c       = VEC[v][6:4];
            acc_lat = int'(VEC[v][3:0]);
            rises0  = se_rises;
            st0     = store_events;
            addr0   = mem_addr;
            do_count(c);
            if (c >= 1 && c <= 4) begin
                check("R1 address", 32'(mem_addr), 32'(4 * c));
                check("R5/R7 stored word", store[c-1], word_of(8'(4 * c)));
                check("R6 one se rise", 32'(se_rises - rises0), 1);
                check("R7 one store", 32'(store_events - st0), 1);
            end else begin
                check("R2 no se", 32'(se_rises - rises0), 0);
                check("R2 no store", 32'(store_events - st0), 0);
                check("R2 addr kept", 32'(mem_addr), 32'(addr0));
            end
        end

        // R5: stray data-valid with sense low has no effect
        @(negedge clk);
        stray = 1'b1;
        repeat (3) @(negedge clk);
        check("R5 stray res_req", 32'(res_req), 0);
        check("R5 stray cnt_ack", 32'(cnt_ack), 0);
        check("R5 stray mem_se", 32'(mem_se), 0);
        check("R5 stray word", res_word, word_of(8'd8));
        stray = 1'b0;
        acc_lat = 0;
        do_count(3'd2);
        check("R5 after stray", store[1], word_of(8'd8));

        // R7: each lane holds its own word after a full sweep
        for (int c = 4; c >= 1; c--) do_count(3'(c));
        for (int c = 1; c <= 4; c++)
            check("R7 lane word", store[c-1], word_of(8'(4 * c)));

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        checks++; fails++;
        $display("FAIL watchdog: cycles %0d expected < 20000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule